// File: doc/BRIEF.md
# SMBus Host Register and Status Unit

This block is the software-facing register file of an SMBus master. Software programs the command type, target device and direction, the command byte and up to two data bytes, then sets a launch bit. The unit raises a one-cycle launch strobe towards a byte-level bus engine, holds a busy flag while that engine works, and turns the engine's completion and error reports into sticky status flags. Bit-level line timing and packet-error-code arithmetic belong to the engine, not to this unit.

The status register mixes two kinds of flag. Done, device error, bus error and failed are final: any of them, with busy clear, means the transaction is over. Byte-done, in-use and alert are informative and never signal the end of a transaction. The unit decodes a `completed` output, a `success`/`error` verdict and an interrupt line by masking the informative flags out. Flags are write-one-to-clear, so writing back a status value just read clears every lingering flag.

Registers sit at byte offsets: 0 control, 1 status, 2 transmit address, 3 command byte, 4 data 0, 5 data 1. Other offsets read as zero and ignore writes.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register, every flag and every output is zero.
- R2: Control (offset 0) holds interrupt enable in bit 0, command type in bits 4:2 (0 quick, 1 byte, 2 byte-data, 3 word-data, 5 block, 6 two-wire block), last-byte in bit 5 and packet-error-code enable in bit 7; these drive the engine outputs and read back, while bit 1 (kill) and bit 6 (start) always read as 0.
- R3: A control write with bit 6 set while busy is clear sets busy and pulses `eng_start` for one cycle on the next clock; the same write while busy is set is ignored entirely (no field changes, no strobe).
- R4: While busy, an engine done, device-error or bus-error report clears busy on the next clock and sets status bit 1, 2 or 3 respectively; these reports have no effect while busy is clear.
- R5: A control write with bit 1 set and bit 6 clear while busy clears busy, sets status bit 4 (failed) and pulses `eng_kill` on the next clock, and engine reports in that cycle are dropped; the kill bit has no effect while busy is clear.
- R6: Status (offset 1) reads busy in bit 0 and flags in bits 7:1; writing a 1 to bits 7:1 clears that flag, writing 0 leaves it, and bit 0 cannot be written. A flag set by an event in the same cycle as its clear stays set.
- R7: Status bit 7 (byte done) is set by an engine byte report while busy, bit 5 (alert) by `alert_in`, and bit 6 (in-use) by a status read; the read returns the value before it sets bit 6.
- R8: `completed` is 1 exactly when busy is clear and at least one of status bits 4:1 is set.
- R9: `success` is 1 exactly when `completed` and, ignoring bits 7:5, the status equals 0x02; `error` is `completed` without `success`.
- R10: `irq` is 1 exactly when control bit 0 is set and `completed` is 1.
- R11: A done report accepted while transmit-address bit 0 is 1 (read) loads data 0 and data 1 from `eng_rdata0`/`eng_rdata1`, overriding a software write in that cycle; with bit 0 at 0 the data registers keep their values.
- R12: Transmit address (offset 2) bits 7:1 drive `eng_dev_addr` and bit 0 drives `eng_read`; offsets 3, 4, 5 drive `eng_hcmd`, `eng_data0`, `eng_data1`, and all read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (side effect on status only) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| eng_start | output | 1 | One-cycle launch strobe to the engine |
| eng_kill | output | 1 | One-cycle abort strobe to the engine |
| eng_cmd | output | 3 | Command type |
| eng_pec_en | output | 1 | Packet-error-code enable |
| eng_last_byte | output | 1 | Last-byte marker |
| eng_dev_addr | output | 7 | Target device address |
| eng_read | output | 1 | Direction, 1 = read |
| eng_hcmd | output | 8 | Command byte |
| eng_data0 | output | 8 | Data byte 0 |
| eng_data1 | output | 8 | Data byte 1 |
| eng_done | input | 1 | Engine: transaction finished cleanly |
| eng_dev_err | input | 1 | Engine: device error |
| eng_bus_err | input | 1 | Engine: bus error |
| eng_byte_done | input | 1 | Engine: one byte moved |
| eng_rdata0 | input | 8 | Engine read result, byte 0 |
| eng_rdata1 | input | 8 | Engine read result, byte 1 |
| alert_in | input | 1 | Alert event from the bus |
| host_busy | output | 1 | Transaction in progress |
| completed | output | 1 | Transaction finished, decoded from status |
| success | output | 1 | Finished with done alone |
| error | output | 1 | Finished with any failure flag |
| irq | output | 1 | Interrupt request |

## Verification
Transactions are run to each ending in turn: clean done in read and write direction, device error, bus error, kill, and done together with device error, which separates a verdict that tests the done bit alone from one that demands done and nothing else. Informative flags (byte done, alert, in-use) are raised around finished transactions to show they change neither `completed` nor the verdict. Launch and kill are tried both while busy and while idle, and engine reports arrive while idle, which tells a correctly gated flag update from one that listens all the time. Write-one-to-clear is tried with full, partial and bit-0-only masks, and a clear colliding with a setting event shows that the set wins.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  localparam int BYTE_W = 8;

  // register offsets
  localparam int OFS_CTRL  = 0;
  localparam int OFS_STAT  = 1;
  localparam int OFS_XADDR = 2;

  // index of each byte register inside the data bank (offset - OFS_XADDR)
  localparam int IX_XADDR = 0;
  localparam int IX_HCMD  = 1;
  localparam int IX_D0    = 2;
  localparam int IX_D1    = 3;

  // control bit positions
  localparam int CB_IE    = 0;
  localparam int CB_KILL  = 1;
  localparam int CB_CMD   = 2;
  localparam int CB_LAST  = 5;
  localparam int CB_START = 6;
  localparam int CB_PEC   = 7;

  // status bit positions
  localparam int SB_BUSY   = 0;
  localparam int SB_DONE   = 1;
  localparam int SB_DEVERR = 2;
  localparam int SB_BUSERR = 3;
  localparam int SB_FAILED = 4;
  localparam int SB_ALERT  = 5;
  localparam int SB_INUSE  = 6;
  localparam int SB_BYTE   = 7;

  // flags that never mean a transaction is over
  localparam logic [BYTE_W-1:0] INFO_MASK = 8'hE0;

  typedef struct packed {
    logic       pec;
    logic       last;
    logic [2:0] cmd;
    logic       ie;
  } ctrl_t;

  function automatic logic sts_completed(input logic [BYTE_W-1:0] s);
    logic [BYTE_W-1:0] fin;
    fin = s & ~INFO_MASK;
    return !s[SB_BUSY] && (fin != '0);
  endfunction

  function automatic logic sts_success(input logic [BYTE_W-1:0] s);
    logic [BYTE_W-1:0] fin;
    fin = s & ~INFO_MASK;
    return sts_completed(s) && (fin == (BYTE_W'(1) << SB_DONE));
  endfunction
endpackage

// File: rtl/smb_ctrl_unit.sv
module smb_ctrl_unit
  import smb_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              busy,
  output ctrl_t             ctrl,
  output logic              start_acc,
  output logic              kill_acc,
  output logic              eng_start,
  output logic              eng_kill
);
  logic start_req;
  logic blocked;

  assign start_req = wr_ctrl && wdata[CB_START];
  assign blocked   = start_req && busy;
  assign start_acc = start_req && !busy;
  assign kill_acc  = wr_ctrl && wdata[CB_KILL] && busy && !start_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      eng_start <= 1'b0;
      eng_kill  <= 1'b0;
    end else begin
      eng_start <= start_acc;
      eng_kill  <= kill_acc;
      if (wr_ctrl && !blocked) begin
        ctrl.ie   <= wdata[CB_IE];
        ctrl.cmd  <= wdata[CB_CMD +: 3];
        ctrl.last <= wdata[CB_LAST];
        ctrl.pec  <= wdata[CB_PEC];
      end
    end
  end
endmodule

// File: rtl/smb_status_unit.sv
module smb_status_unit
  import smb_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w1c_en,
  input  logic [BYTE_W-1:1] w1c_bits,
  input  logic              rd_status,
  input  logic              start_acc,
  input  logic              kill_acc,
  input  logic              eng_done,
  input  logic              eng_dev_err,
  input  logic              eng_bus_err,
  input  logic              eng_byte_done,
  input  logic              alert_in,
  output logic              busy,
  output logic [BYTE_W-1:1] flags,
  output logic              done_acc
);
  logic              active;
  logic              finish;
  logic [BYTE_W-1:1] set_vec;
  logic [BYTE_W-1:1] clr_vec;

  assign active   = busy && !kill_acc;
  assign done_acc = active && eng_done;
  assign finish   = active && (eng_done || eng_dev_err || eng_bus_err);

  always_comb begin
    set_vec            = '0;
    set_vec[SB_DONE]   = done_acc;
    set_vec[SB_DEVERR] = active && eng_dev_err;
    set_vec[SB_BUSERR] = active && eng_bus_err;
    set_vec[SB_FAILED] = kill_acc;
    set_vec[SB_ALERT]  = alert_in;
    set_vec[SB_INUSE]  = rd_status;
    set_vec[SB_BYTE]   = active && eng_byte_done;
    clr_vec            = w1c_en ? w1c_bits : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      flags <= '0;
    end else begin
      flags <= (flags & ~clr_vec) | set_vec;
      if (start_acc)                busy <= 1'b1;
      else if (kill_acc || finish)  busy <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_byte_bank.sv
module smb_byte_bank
  import smb_host_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [BYTE_W-1:0]             wdata,
  input  logic [NBYTES-1:0]             load_vec,
  input  logic [NBYTES-1:0][BYTE_W-1:0] load_val,
  output logic [NBYTES-1:0][BYTE_W-1:0] q
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)           q[i] <= '0;
      else if (load_vec[i]) q[i] <= load_val[i];
      else if (hit)         q[i] <= wdata;
    end
  end
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              eng_start,
  output logic              eng_kill,
  output logic [2:0]        eng_cmd,
  output logic              eng_pec_en,
  output logic              eng_last_byte,
  output logic [BYTE_W-2:0] eng_dev_addr,
  output logic              eng_read,
  output logic [BYTE_W-1:0] eng_hcmd,
  output logic [BYTE_W-1:0] eng_data0,
  output logic [BYTE_W-1:0] eng_data1,
  input  logic              eng_done,
  input  logic              eng_dev_err,
  input  logic              eng_bus_err,
  input  logic              eng_byte_done,
  input  logic [BYTE_W-1:0] eng_rdata0,
  input  logic [BYTE_W-1:0] eng_rdata1,
  input  logic              alert_in,
  output logic              host_busy,
  output logic              completed,
  output logic              success,
  output logic              error,
  output logic              irq
);
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  // named internal events (used by the bound checker)
  logic              wr_ctrl, wr_stat, rd_stat;
  logic              start_acc, kill_acc, done_acc, rd_done;
  logic              bank_hit;
  logic [ADDR_W-1:0] rel;
  logic [BYTE_W-1:0] status_view;
  logic [BYTE_W-1:1] flags;
  ctrl_t             ctrl;

  logic [NBYTES-1:0]             load_vec;
  logic [NBYTES-1:0][BYTE_W-1:0] load_val;
  logic [NBYTES-1:0][BYTE_W-1:0] bytes_q;

  assign wr_ctrl  = reg_wr_en && (reg_addr == ADDR_W'(OFS_CTRL));
  assign wr_stat  = reg_wr_en && (reg_addr == ADDR_W'(OFS_STAT));
  assign rd_stat  = reg_rd_en && (reg_addr == ADDR_W'(OFS_STAT));
  assign rel      = reg_addr - ADDR_W'(OFS_XADDR);
  assign bank_hit = (reg_addr >= ADDR_W'(OFS_XADDR)) && (rel < ADDR_W'(NBYTES));

  smb_ctrl_unit u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .wdata     (reg_wdata),
    .busy      (host_busy),
    .ctrl      (ctrl),
    .start_acc (start_acc),
    .kill_acc  (kill_acc),
    .eng_start (eng_start),
    .eng_kill  (eng_kill)
  );

  smb_status_unit u_stat (
    .clk           (clk),
    .rst_n         (rst_n),
    .w1c_en        (wr_stat),
    .w1c_bits      (reg_wdata[BYTE_W-1:1]),
    .rd_status     (rd_stat),
    .start_acc     (start_acc),
    .kill_acc      (kill_acc),
    .eng_done      (eng_done),
    .eng_dev_err   (eng_dev_err),
    .eng_bus_err   (eng_bus_err),
    .eng_byte_done (eng_byte_done),
    .alert_in      (alert_in),
    .busy          (host_busy),
    .flags         (flags),
    .done_acc      (done_acc)
  );

  assign rd_done = done_acc && bytes_q[IX_XADDR][0];

  always_comb begin
    load_vec        = '0;
    load_val        = '0;
    load_vec[IX_D0] = rd_done;
    load_vec[IX_D1] = rd_done;
    load_val[IX_D0] = eng_rdata0;
    load_val[IX_D1] = eng_rdata1;
  end

  smb_byte_bank #(.NBYTES(NBYTES)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en && bank_hit),
    .wr_idx   (rel[IDX_W-1:0]),
    .wdata    (reg_wdata),
    .load_vec (load_vec),
    .load_val (load_val),
    .q        (bytes_q)
  );

  assign status_view = {flags, host_busy};
  assign completed   = sts_completed(status_view);
  assign success     = sts_success(status_view);
  assign error       = completed && !success;
  assign irq         = ctrl.ie && completed;

  assign eng_cmd       = ctrl.cmd;
  assign eng_pec_en    = ctrl.pec;
  assign eng_last_byte = ctrl.last;
  assign eng_dev_addr  = bytes_q[IX_XADDR][BYTE_W-1:1];
  assign eng_read      = bytes_q[IX_XADDR][0];
  assign eng_hcmd      = bytes_q[IX_HCMD];
  assign eng_data0     = bytes_q[IX_D0];
  assign eng_data1     = bytes_q[IX_D1];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFS_CTRL)) begin
      reg_rdata[CB_IE]       = ctrl.ie;
      reg_rdata[CB_CMD +: 3] = ctrl.cmd;
      reg_rdata[CB_LAST]     = ctrl.last;
      reg_rdata[CB_PEC]      = ctrl.pec;
    end else if (reg_addr == ADDR_W'(OFS_STAT)) begin
      reg_rdata = status_view;
    end else if (bank_hit) begin
      reg_rdata = bytes_q[rel[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/smb_host_chk.sv
module smb_host_chk
  import smb_host_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic              host_busy,
  input logic              eng_start,
  input logic              eng_kill,
  input logic              eng_done,
  input logic              completed,
  input logic              success,
  input logic              error,
  input logic              irq,
  input logic              start_acc,
  input logic              kill_acc,
  input logic [BYTE_W-1:0] status_view
);
  logic stat_wr, ctrl_start_wr;
  assign stat_wr       = reg_wr_en && (reg_addr == ADDR_W'(OFS_STAT));
  assign ctrl_start_wr = reg_wr_en && (reg_addr == ADDR_W'(OFS_CTRL)) && reg_wdata[CB_START];

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (host_busy && eng_start));

  assert_start_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_start_wr && host_busy) |=> !eng_start);

  assert_idle_report_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_busy && eng_done && !stat_wr) |=> $stable(status_view[SB_DONE]));

  assert_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kill_acc |=> (!host_busy && status_view[SB_FAILED] && eng_kill));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[SB_DONE] && !host_busy) |=> !status_view[SB_DONE]);

  assert_completed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    completed |-> !host_busy);

  assert_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    completed |-> $onehot({success, error}));

  assert_idle_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !completed |-> !(success || error));

  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_view[SB_FAILED:SB_DONE] != '0));
endmodule

bind smb_host_regs smb_host_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/smb_host_regs_bench.sv
`timescale 1ns/1ps
module smb_host_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 0, reg_rd_en = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       eng_start, eng_kill, eng_pec_en, eng_last_byte, eng_read;
  logic [2:0] eng_cmd;
  logic [6:0] eng_dev_addr;
  logic [7:0] eng_hcmd, eng_data0, eng_data1;
  logic       eng_done = 0, eng_dev_err = 0, eng_bus_err = 0, eng_byte_done = 0;
  logic [7:0] eng_rdata0 = 0, eng_rdata1 = 0;
  logic       alert_in = 0;
  logic       host_busy, completed, success, error, irq;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  smb_host_regs u_smb_host_regs (.*);

  // ---------------- reference model ----------------
  logic       m_ie, m_pec, m_last, m_busy, m_start, m_kill;
  logic [2:0] m_cmd;
  logic [7:0] m_fl;        // bit 0 unused
  logic [7:0] m_b[4];      // xaddr, hcmd, d0, d1

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ie = 0; m_pec = 0; m_last = 0; m_busy = 0; m_start = 0; m_kill = 0;
      m_cmd = 0; m_fl = 0;
      foreach (m_b[i]) m_b[i] = 0;
    end else begin
      bit wc, ignore, st, kl, act, rdl;
      int a;
      a      = reg_addr;
      wc     = reg_wr_en && a == 0;
      ignore = wc && reg_wdata[6] && m_busy;
      st     = wc && reg_wdata[6] && !m_busy;
      kl     = wc && reg_wdata[1] && !reg_wdata[6] && m_busy;
      act    = m_busy && !kl;
      rdl    = act && eng_done && m_b[0][0];
      if (reg_wr_en && a == 1) m_fl = m_fl & ~{reg_wdata[7:1], 1'b0};
      if (alert_in) m_fl[5] = 1;
      if (reg_rd_en && a == 1) m_fl[6] = 1;
      if (kl) m_fl[4] = 1;
      if (act) begin
        if (eng_done)      m_fl[1] = 1;
        if (eng_dev_err)   m_fl[2] = 1;
        if (eng_bus_err)   m_fl[3] = 1;
        if (eng_byte_done) m_fl[7] = 1;
      end
      if (st) m_busy = 1;
      else if (kl || (act && (eng_done || eng_dev_err || eng_bus_err))) m_busy = 0;
      m_start = st;
      m_kill  = kl;
      if (wc && !ignore) begin
        m_ie = reg_wdata[0]; m_cmd = reg_wdata[4:2];
        m_last = reg_wdata[5]; m_pec = reg_wdata[7];
      end
      if (reg_wr_en && a >= 2 && a <= 5) m_b[a-2] = reg_wdata;
      if (rdl) begin m_b[2] = eng_rdata0; m_b[3] = eng_rdata1; end
    end
  end

  task automatic chk(input string req, input string nm, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (cmp_on) begin
      logic [7:0] e_rd;
      int nfin;
      bit e_cmp, e_ok;
      nfin  = m_fl[1] + m_fl[2] + m_fl[3] + m_fl[4];
      e_cmp = !m_busy && nfin > 0;
      e_ok  = e_cmp && nfin == 1 && m_fl[1];
      case (reg_addr)
        0: e_rd = {m_pec, 1'b0, m_last, m_cmd, 1'b0, m_ie};
        1: e_rd = {m_fl[7:1], m_busy};
        2, 3, 4, 5: e_rd = m_b[reg_addr-2];
        default: e_rd = 0;
      endcase
      chk("R2/R6/R7", "reg_rdata", reg_rdata, e_rd);
      chk("R2", "eng_cmd", {5'b0, eng_cmd}, {5'b0, m_cmd});
      chk("R2", "pec/last", {6'b0, eng_pec_en, eng_last_byte}, {6'b0, m_pec, m_last});
      chk("R3", "eng_start", {7'b0, eng_start}, {7'b0, m_start});
      chk("R4", "host_busy", {7'b0, host_busy}, {7'b0, m_busy});
      chk("R5", "eng_kill", {7'b0, eng_kill}, {7'b0, m_kill});
      chk("R8", "completed", {7'b0, completed}, {7'b0, e_cmp});
      chk("R9", "success/error", {6'b0, success, error}, {6'b0, e_ok, e_cmp && !e_ok});
      chk("R10", "irq", {7'b0, irq}, {7'b0, m_ie && e_cmp});
      chk("R11", "eng_data0", eng_data0, m_b[2]);
      chk("R11", "eng_data1", eng_data1, m_b[3]);
      chk("R12", "dev_addr/read", {eng_dev_addr, eng_read}, m_b[0]);
      chk("R12", "eng_hcmd", eng_hcmd, m_b[1]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input logic w, input logic r, input logic [2:0] a, input logic [7:0] d,
                     input logic [3:0] ev, input logic al);
    @(negedge clk);
    reg_wr_en = w; reg_rd_en = r; reg_addr = a; reg_wdata = d;
    {eng_byte_done, eng_bus_err, eng_dev_err, eng_done} = ev;
    alert_in = al;
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d); cyc(1, 0, a, d, 4'h0, 0); endtask
  task automatic rd(input logic [2:0] a);                      cyc(0, 1, a, 8'h00, 4'h0, 0); endtask
  task automatic ev(input logic [3:0] e);                      cyc(0, 0, 3'd1, 8'h00, e, 0); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 3'd1, 8'h00, 4'h0, 0);
  endtask

  localparam logic [3:0] EV_DONE = 4'b0001, EV_DEV = 4'b0010, EV_BUS = 4'b0100, EV_BYTE = 4'b1000;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state at the ports
    chk("R1", "rdata@stat", reg_rdata, 8'h00);
    chk("R1", "busy/cmp/irq/strobes",
        {3'b0, host_busy, completed, irq, eng_start, eng_kill}, 8'h00);
    chk("R1", "data/addr", eng_data0 | eng_data1 | eng_hcmd | {eng_dev_addr, eng_read}, 8'h00);
    cmp_on = 1;

    // setup: byte-data read of device 0x50, interrupts on
    wr(0, 8'h09); wr(2, 8'hA1); wr(3, 8'h10); wr(4, 8'h00); wr(5, 8'h77);
    rd(0); rd(2); rd(3); rd(4); rd(6); rd(7);
    wr(6, 8'hFF); rd(6);
    // R3 launch, then blocked relaunch
    wr(0, 8'h49); idle(2);
    wr(0, 8'h4D); idle(1); rd(0);
    // R7 byte report while busy, R11 read completion loads data
    ev(EV_BYTE); idle(1);
    cyc(0, 0, 3'd1, 8'h00, EV_DONE, 0);
    @(negedge clk); eng_rdata0 = 8'h5A; eng_rdata1 = 8'hC3;
    idle(0);
    idle(2);
    // relaunch and complete with read data present
    wr(1, 8'hFE); wr(0, 8'h49);
    @(negedge clk); reg_wr_en = 0; eng_done = 1; eng_rdata0 = 8'h3C; eng_rdata1 = 8'h96;
    @(negedge clk); eng_done = 0;
    rd(4); rd(5);
    // R7 in-use set by status read, R6 partial clear
    rd(1); rd(1); wr(1, 8'h40); rd(1); wr(1, 8'h02); rd(1);
    // write direction: data untouched on done
    wr(2, 8'hA0); wr(0, 8'h49); ev(EV_DONE); idle(1); rd(4);
    // R4 device error, then bus error
    wr(1, 8'hFE); wr(0, 8'h49); idle(1); ev(EV_DEV); idle(1);
    wr(1, 8'hFE); wr(0, 8'h4D); ev(EV_BUS); idle(1); rd(1);
    // R9 done plus device error together
    wr(1, 8'hFE); wr(0, 8'h49); ev(EV_DONE | EV_DEV); idle(1);
    // R5 kill while busy, with a report in the same cycle
    wr(1, 8'hFE); wr(0, 8'h49); idle(1);
    cyc(1, 0, 3'd0, 8'h0B, EV_DONE | EV_BYTE, 0); idle(2); rd(1);
    // R5 kill while idle ignored, R4 reports while idle ignored
    wr(1, 8'hFE); wr(0, 8'h02); idle(1); ev(EV_DONE); ev(EV_DEV); ev(EV_BUS); ev(EV_BYTE); idle(1);
    // R7 alert, R6 bit 0 not writable, set beats clear
    cyc(0, 0, 3'd1, 8'h00, 4'h0, 1); idle(1);
    wr(1, 8'h01); cyc(1, 0, 3'd1, 8'h20, 4'h0, 1); idle(1); wr(1, 8'hFE); idle(1);
    // R10 interrupt disabled, R2 other command codes
    wr(0, 8'h40); ev(EV_DONE); idle(1);
    wr(0, 8'h94); rd(0); wr(0, 8'h38); rd(0); wr(0, 8'h81); wr(1, 8'hFE); idle(2);
    // done with a W1C of done in the same cycle: set wins
    wr(0, 8'h49); cyc(1, 0, 3'd1, 8'h02, EV_DONE, 0); idle(2);

    cmp_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog (R1..) actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule